// File: doc/BRIEF.md
# Block-Copy DMA into Video Memory

This block copies data into video memory in fixed 16-byte blocks. Software loads a source address and a destination address, each as a high and a low byte register, then writes a control register. Writing control takes a snapshot of both addresses. The source is aligned down to a block boundary. The destination is folded into the 8 KiB video window and aligned the same way. The control write then starts one of two kinds of copy. In bulk mode the whole length moves at once while the processor is held. In line-gap mode one block moves each time the horizontal-blank pulse arrives.

Each byte takes two clock cycles. In the first cycle the block issues a read of the source. In the second it writes the returned byte to the destination. Both address counters step by one. The processor stall output stays high for as long as bytes are moving. When a copy finishes, the advanced addresses are written back into the four address registers. The control register then shows progress. In line-gap mode it counts down one per block. In bulk mode its top bit is set when the copy is done.

Top module: `vram_block_dma`

## Requirements
- R1: On an accepted control write, the working source address is {src_hi, src_lo} with its low 4 bits cleared, and the first read is issued at that address.
- R2: On an accepted control write, the working destination address is ({dst_hi, dst_lo} & 0x1FF0) | 0x8000.
- R3: If the aligned source lies in 0x8000–0x9FFF, the control write is ignored: no transfer starts, and the control register and mode are unchanged. A source of 0xA000 is accepted.
- R4: A control write with bit 7 = 0, made while line-gap mode is inactive, starts a bulk copy in the next cycle. The copy moves ((value & 0x7F) + 1) × 16 bytes and holds cpu_stall high for exactly 2 cycles per byte.
- R5: Each byte is moved as follows. In one cycle a read is issued at the source address. In the next cycle a write goes to the destination address, carrying the byte the memory returned. Both addresses then advance by one. A read and a write are never issued in the same cycle.
- R6: At the end of any copy, the address registers hold the address that follows the last source byte and the address that follows the last destination byte. After a bulk copy, the control register reads 0x80 | n.
- R7: A control write with bit 7 = 1 enters line-gap mode. The control register stores the value with bit 7 cleared, and nothing moves until a pulse arrives. Each pulse then moves one 16-byte block, with cpu_stall held high for 32 cycles.
- R8: Each completed line-gap block decrements the control register. The block that takes it from 0x00 to 0xFF ends line-gap mode, and later pulses do nothing.
- R9: A horizontal-blank pulse is ignored while line-gap mode is inactive, and also while a block is already moving.
- R10: A control write with bit 7 = 0 during line-gap mode ends that mode without moving data. A control write with bit 7 = 1 during line-gap mode reloads the addresses and the count without moving data.
- R11: Register writes are ignored while cpu_stall is high.
- R12: After reset, all five registers read 0, cpu_stall is low, and no memory read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| reg_wdata | input | 8 | Register write data |
| hblank_pulse | input | 1 | One-cycle horizontal-blank pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| cpu_stall | output | 1 | Processor hold while bytes move |
| reg_src_hi | output | 8 | Source high register |
| reg_src_lo | output | 8 | Source low register |
| reg_dst_hi | output | 8 | Destination high register |
| reg_dst_lo | output | 8 | Destination low register |
| reg_ctrl | output | 8 | Control register |

## Verification
The copy engine is driven with several patterns:
- Bulk copies from an unaligned source into a destination that needs folding. These separate the masking rules from the counting rule.
- Sources on either side of the forbidden window (0x9FFx and 0xA00x). These show the window's exact edges.
- Line-gap sequences run until the count wraps. These are mixed with extra pulses that arrive early, late or during a block, which tells the one-block-per-pulse rule apart from edge or level sensitivity.
- Cancel and reload writes made mid-mode, along with register writes made while stalled. These show that no stray bytes move and no stray register updates occur.

A reference model built from integers predicts every port on every clock.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } vbd_sel_e;

  typedef enum logic {
    PH_RD = 1'b0,
    PH_WR = 1'b1
  } vbd_phase_e;

endpackage

// File: rtl/vbd_addr_gen.sv
module vbd_addr_gen #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int VRAM_BASE   = 32'h8000,
  parameter int VRAM_SIZE   = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] src_raw,
  input  logic [ADDR_W-1:0] dst_raw,
  input  logic              load,
  input  logic              step_src,
  input  logic              step_dst,
  output logic              src_bad,
  output logic [ADDR_W-1:0] src_cnt,
  output logic [ADDR_W-1:0] dst_cnt
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_BYTES - 1);
  localparam logic [ADDR_W-1:0] DST_MASK   = ADDR_W'(VRAM_SIZE - 1) & ALIGN_MASK;
  localparam logic [ADDR_W-1:0] VBASE      = ADDR_W'(VRAM_BASE);
  localparam logic [ADDR_W:0]   VEND       = (ADDR_W+1)'(VRAM_BASE + VRAM_SIZE);

  logic [ADDR_W-1:0] src_aligned;
  logic [ADDR_W-1:0] dst_mapped;

  assign src_aligned = src_raw & ALIGN_MASK;
  assign dst_mapped  = (dst_raw & DST_MASK) | VBASE;
  assign src_bad     = (src_aligned >= VBASE) && ({1'b0, src_aligned} < VEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_cnt <= '0;
      dst_cnt <= '0;
    end else if (load) begin
      src_cnt <= src_aligned;
      dst_cnt <= dst_mapped;
    end else begin
      if (step_src) src_cnt <= src_cnt + ADDR_W'(1);
      if (step_dst) dst_cnt <= dst_cnt + ADDR_W'(1);
    end
  end

  // R5: the source advances by exactly one after each read cycle
  p_src_step_r5: assert property (@(posedge clk) disable iff (rst)
    step_src && !load |=> src_cnt == $past(src_cnt) + ADDR_W'(1));

  // R2: a freshly loaded destination is aligned and inside the video window
  p_dst_window_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> ((dst_cnt & ~ALIGN_MASK) == '0) && (dst_cnt >= VBASE) && ({1'b0, dst_cnt} < VEND));

endmodule

// File: rtl/vbd_seq.sv
module vbd_seq
  import vbd_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int BLOCK_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             hb_mode_in,
  input  logic [CNT_W-1:0] len_field,
  input  logic             hblank_pulse,
  input  logic             ctrl_zero,
  output logic             busy,
  output logic             hb_active,
  output logic             done,
  output logic             step_src,
  output logic             step_dst
);

  localparam int SHIFT = $clog2(BLOCK_BYTES);
  localparam int LEN_W = CNT_W + SHIFT + 1;

  vbd_phase_e         phase;
  logic [LEN_W-1:0]   left;
  logic [LEN_W-1:0]   len_gen;
  logic [LEN_W-1:0]   len_blk;
  logic               start_gen;
  logic               start_hb;

  assign len_gen   = LEN_W'({1'b0, len_field} + (CNT_W+1)'(1)) << SHIFT;
  assign len_blk   = LEN_W'(BLOCK_BYTES);
  assign start_gen = accept && !hb_active && !hb_mode_in;
  assign start_hb  = hb_active && hblank_pulse && !busy && !accept;
  assign step_src  = busy && (phase == PH_RD);
  assign step_dst  = busy && (phase == PH_WR);
  assign done      = step_dst && (left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_active <= 1'b0;
    end else if (accept) begin
      hb_active <= hb_mode_in;
    end else if (done && hb_active && ctrl_zero) begin
      hb_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= PH_RD;
      left  <= '0;
    end else if (start_gen || start_hb) begin
      busy  <= 1'b1;
      phase <= PH_RD;
      left  <= start_gen ? len_gen : len_blk;
    end else if (busy) begin
      if (phase == PH_RD) begin
        phase <= PH_WR;
      end else begin
        phase <= PH_RD;
        left  <= left - LEN_W'(1);
        if (left == LEN_W'(1)) busy <= 1'b0;
      end
    end
  end

  // R4: every read cycle is followed by its write cycle
  p_wr_follows_rd_r4: assert property (@(posedge clk) disable iff (rst)
    step_src |=> step_dst);

  // R8: the wrapping block ends line-gap mode and the engine idles
  p_hb_end_r8: assert property (@(posedge clk) disable iff (rst)
    done && hb_active && ctrl_zero |=> !hb_active && !busy);

  // R9: with line-gap mode off, a pulse never starts a copy
  p_pulse_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !hb_active && !busy && !accept |=> !busy);

endmodule

// File: rtl/vbd_regs.sv
module vbd_regs
  import vbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [2:0]            reg_sel,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  busy,
  input  logic                  accept,
  input  logic                  done,
  input  logic                  hb_active,
  input  logic [2*DATA_W-1:0]   src_wb,
  input  logic [2*DATA_W-1:0]   dst_wb,
  output logic [DATA_W-1:0]     src_hi_q,
  output logic [DATA_W-1:0]     src_lo_q,
  output logic [DATA_W-1:0]     dst_hi_q,
  output logic [DATA_W-1:0]     dst_lo_q,
  output logic [DATA_W-1:0]     ctrl_q
);

  vbd_sel_e sel;
  assign sel = vbd_sel_e'(reg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
      ctrl_q   <= '0;
    end else if (done) begin
      src_hi_q <= src_wb[2*DATA_W-1:DATA_W];
      src_lo_q <= src_wb[DATA_W-1:0];
      dst_hi_q <= dst_wb[2*DATA_W-1:DATA_W];
      dst_lo_q <= dst_wb[DATA_W-1:0];
      if (hb_active) ctrl_q <= ctrl_q - DATA_W'(1);
      else           ctrl_q <= {1'b1, ctrl_q[DATA_W-2:0]};
    end else if (reg_we && !busy) begin
      case (sel)
        SEL_SRC_HI: src_hi_q <= reg_wdata;
        SEL_SRC_LO: src_lo_q <= reg_wdata;
        SEL_DST_HI: dst_hi_q <= reg_wdata;
        SEL_DST_LO: dst_lo_q <= reg_wdata;
        SEL_CTRL:   if (accept) ctrl_q <= {1'b0, reg_wdata[DATA_W-2:0]};
        default:    ;
      endcase
    end
  end

  // R11: while a copy runs and is not finishing, no register moves
  p_hold_busy_r11: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> $stable(ctrl_q) && $stable(src_hi_q) && $stable(src_lo_q)
                      && $stable(dst_hi_q) && $stable(dst_lo_q));

  // R6: a finished bulk copy shows its completion flag
  p_gen_flag_r6: assert property (@(posedge clk) disable iff (rst)
    done && !hb_active |=> ctrl_q[DATA_W-1]);

endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
  import vbd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 16,
  parameter int VRAM_BASE   = 32'h8000,
  parameter int VRAM_SIZE   = 8192
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [2:0]            reg_sel,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  hblank_pulse,
  output logic                  mem_rd_en,
  output logic [2*DATA_W-1:0]   mem_rd_addr,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic                  mem_wr_en,
  output logic [2*DATA_W-1:0]   mem_wr_addr,
  output logic [DATA_W-1:0]     mem_wr_data,
  output logic                  cpu_stall,
  output logic [DATA_W-1:0]     reg_src_hi,
  output logic [DATA_W-1:0]     reg_src_lo,
  output logic [DATA_W-1:0]     reg_dst_hi,
  output logic [DATA_W-1:0]     reg_dst_lo,
  output logic [DATA_W-1:0]     reg_ctrl
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int CNT_W  = DATA_W - 1;

  logic              busy, hb_active, done, step_src, step_dst;
  logic              src_bad, accept;
  logic [ADDR_W-1:0] src_cnt, dst_cnt, dst_wb;

  assign accept = reg_we && !busy && (vbd_sel_e'(reg_sel) == SEL_CTRL) && !src_bad;
  assign dst_wb = dst_cnt + ADDR_W'(1);

  vbd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .accept(accept), .done(done), .hb_active(hb_active),
    .src_wb(src_cnt), .dst_wb(dst_wb),
    .src_hi_q(reg_src_hi), .src_lo_q(reg_src_lo),
    .dst_hi_q(reg_dst_hi), .dst_lo_q(reg_dst_lo), .ctrl_q(reg_ctrl)
  );

  vbd_addr_gen #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES),
    .VRAM_BASE(VRAM_BASE), .VRAM_SIZE(VRAM_SIZE)
  ) u_addr (
    .clk(clk), .rst(rst),
    .src_raw({reg_src_hi, reg_src_lo}), .dst_raw({reg_dst_hi, reg_dst_lo}),
    .load(accept), .step_src(step_src), .step_dst(step_dst),
    .src_bad(src_bad), .src_cnt(src_cnt), .dst_cnt(dst_cnt)
  );

  vbd_seq #(.CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)) u_seq (
    .clk(clk), .rst(rst), .accept(accept),
    .hb_mode_in(reg_wdata[DATA_W-1]), .len_field(reg_wdata[CNT_W-1:0]),
    .hblank_pulse(hblank_pulse), .ctrl_zero(reg_ctrl == '0),
    .busy(busy), .hb_active(hb_active), .done(done),
    .step_src(step_src), .step_dst(step_dst)
  );

  assign mem_rd_en   = step_src;
  assign mem_rd_addr = src_cnt;
  assign mem_wr_en   = step_dst;
  assign mem_wr_addr = dst_cnt;
  assign mem_wr_data = mem_rd_data;
  assign cpu_stall   = busy;

  // R3: a control write with a source in the video window starts nothing
  p_bad_src_r3: assert property (@(posedge clk) disable iff (rst)
    reg_we && !cpu_stall && (vbd_sel_e'(reg_sel) == SEL_CTRL) && src_bad
      |=> !cpu_stall && $stable(reg_ctrl));

  // R5: memory reads and writes are never issued together
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

endmodule

// File: tb/vram_block_dma_bench.sv
module vram_block_dma_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic        hblank_pulse = 1'b0;
  logic        mem_rd_en, mem_wr_en, cpu_stall;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data = 8'd0;
  logic [7:0]  mem_wr_data;
  logic [7:0]  reg_src_hi, reg_src_lo, reg_dst_hi, reg_dst_lo, reg_ctrl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vram_block_dma u_vram_block_dma (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .hblank_pulse(hblank_pulse),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .cpu_stall(cpu_stall),
    .reg_src_hi(reg_src_hi), .reg_src_lo(reg_src_lo),
    .reg_dst_hi(reg_dst_hi), .reg_dst_lo(reg_dst_lo), .reg_ctrl(reg_ctrl)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monotonic observation counters
  int wcount = 0, rcount = 0, scount = 0;
  int rmark = 0, wmark = 0;
  int first_rd = 0, first_wr = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (mem_rd_en) begin
        if (rcount == rmark) first_rd = mem_rd_addr;
        rcount++;
      end
      if (mem_wr_en) begin
        if (wcount == wmark) first_wr = mem_wr_addr;
        wcount++;
      end
      if (cpu_stall) scount++;
    end
  end

  // behavioural reference model
  int m_busy = 0, m_ph = 0, m_left = 0, m_hb = 0;
  int m_src = 0, m_dst = 0, last_rd = 0;
  int r [5] = '{0, 0, 0, 0, 0};

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_ph = 0; m_left = 0; m_hb = 0; m_src = 0; m_dst = 0;
      for (int i = 0; i < 5; i++) r[i] = 0;
    end else begin
      int srcr, dstr, acc, pre_busy, pre_hb;
      srcr = ((r[0] << 8) | r[1]) & 'hFFF0;
      dstr = (((r[2] << 8) | r[3]) & 'h1FF0) | 'h8000;
      pre_busy = m_busy;
      pre_hb = m_hb;
      acc = (reg_we && !pre_busy && reg_sel == 4 && !(srcr >= 'h8000 && srcr < 'hA000)) ? 1 : 0;
      if (pre_busy) begin
        if (m_ph == 0) begin
          last_rd = m_src; m_src = (m_src + 1) & 'hFFFF; m_ph = 1;
        end else begin
          m_dst = (m_dst + 1) & 'hFFFF; m_left--; m_ph = 0;
          if (m_left == 0) begin
            m_busy = 0;
            r[0] = m_src >> 8; r[1] = m_src & 'hFF;
            r[2] = m_dst >> 8; r[3] = m_dst & 'hFF;
            if (m_hb != 0) begin
              r[4] = (r[4] - 1) & 'hFF;
              if (r[4] == 'hFF) m_hb = 0;
            end else r[4] = r[4] | 'h80;
          end
        end
      end else if (reg_we) begin
        if (reg_sel < 4) r[reg_sel] = reg_wdata;
        else if (acc != 0) begin
          r[4] = reg_wdata & 'h7F;
          m_src = srcr; m_dst = dstr;
          if (pre_hb == 0 && reg_wdata[7] == 1'b0) begin
            m_busy = 1; m_ph = 0; m_left = ((reg_wdata & 'h7F) + 1) * 16;
          end
          m_hb = reg_wdata[7];
        end
      end
      if (!pre_busy && acc == 0 && pre_hb != 0 && hblank_pulse) begin
        m_busy = 1; m_ph = 0; m_left = 16;
      end
    end
  end

  // per-cycle comparison, away from both clock edges
  always @(posedge clk) begin
    #4;
    if (!rst) begin
      chk("R4 cpu_stall", cpu_stall, m_busy);
      chk("R5 mem_rd_en", mem_rd_en, (m_busy != 0 && m_ph == 0) ? 1 : 0);
      chk("R5 mem_wr_en", mem_wr_en, (m_busy != 0 && m_ph == 1) ? 1 : 0);
      if (m_busy != 0 && m_ph == 0) chk("R1 mem_rd_addr", mem_rd_addr, m_src);
      if (m_busy != 0 && m_ph == 1) begin
        chk("R2 mem_wr_addr", mem_wr_addr, m_dst);
        chk("R5 mem_wr_data", mem_wr_data, memf(16'(last_rd)));
      end
      chk("R6 reg_src", {reg_src_hi, reg_src_lo}, (r[0] << 8) | r[1]);
      chk("R6 reg_dst", {reg_dst_hi, reg_dst_lo}, (r[2] << 8) | r[3]);
      chk("R8 reg_ctrl", reg_ctrl, r[4]);
    end
  end

  task automatic wr(input int s, input int v);
    @(negedge clk); reg_we = 1'b1; reg_sel = 3'(s); reg_wdata = 8'(v);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); hblank_pulse = 1'b1;
    @(negedge clk); hblank_pulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!cpu_stall) break;
    end
    idle(2);
  endtask

  task automatic setup(input int src, input int dst);
    wr(0, src >> 8); wr(1, src & 'hFF); wr(2, dst >> 8); wr(3, dst & 'hFF);
    rmark = rcount; wmark = wcount;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0, s0;
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R12 reset state
    chk("R12 stall after reset", cpu_stall, 0);
    chk("R12 ctrl after reset", reg_ctrl, 0);
    chk("R12 src after reset", {reg_src_hi, reg_src_lo}, 0);
    chk("R12 no read after reset", mem_rd_en, 0);

    // bulk copy, unaligned source, destination needing fold
    setup('h1234, 'hFF47);
    s0 = scount;
    wr(4, 'h02);
    // R11: writes while stalled are ignored
    wr(0, 'h77); wr(4, 'h05);
    wait_idle();
    chk("R1 first read aligned", first_rd, 'h1230);
    chk("R2 first write folded", first_wr, 'h9F40);
    chk("R4 bytes in bulk copy", wcount - wmark, 48);
    chk("R4 stall cycles", scount - s0, 96);
    chk("R6 src writeback", {reg_src_hi, reg_src_lo}, 'h1260);
    chk("R6 dst writeback", {reg_dst_hi, reg_dst_lo}, 'h9F70);
    chk("R6 ctrl done flag", reg_ctrl, 'h82);
    chk("R11 src_hi write dropped", reg_src_hi, 'h12);

    // R3 invalid sources, both window edges
    setup('h8800, 'h8000);
    wr(4, 'h05); idle(10);
    chk("R3 low-window source ignored", wcount - wmark, 0);
    chk("R3 ctrl unchanged", reg_ctrl, 'h82);
    setup('h9FFF, 'h8000);
    wr(4, 'h85); idle(10); pulse(); idle(10);
    chk("R3 top-of-window source ignored", wcount - wmark, 0);
    setup('hA00F, 'hFFFF);
    wr(4, 'h00); wait_idle();
    chk("R3 source 0xA000 accepted", first_rd, 'hA000);
    chk("R2 destination 0x9FF0", first_wr, 'h9FF0);
    chk("R4 single-block bulk", wcount - wmark, 16);

    // R9 pulse with line-gap mode off
    pulse(); idle(10);
    chk("R9 pulse ignored when idle", wcount - wmark, 16);

    // R7/R8 line-gap mode
    setup('h4000, 'h8000);
    wr(4, 'h81); idle(10);
    chk("R7 ctrl stored without bit 7", reg_ctrl, 'h01);
    chk("R7 nothing before pulse", wcount - wmark, 0);
    s0 = scount;
    pulse(); wait_idle();
    chk("R7 one block per pulse", wcount - wmark, 16);
    chk("R7 stall per block", scount - s0, 32);
    chk("R8 ctrl decremented", reg_ctrl, 'h00);
    chk("R6 src after block", {reg_src_hi, reg_src_lo}, 'h4010);
    pulse(); wait_idle();
    chk("R8 ctrl wrapped", reg_ctrl, 'hFF);
    chk("R8 second block", wcount - wmark, 32);
    pulse(); idle(40);
    chk("R8 pulse after wrap ignored", wcount - wmark, 32);

    // R9 pulse during a moving block
    setup('h2000, 'h8100);
    wr(4, 'h82);
    pulse(); idle(4); pulse(); wait_idle();
    chk("R9 pulse while busy ignored", wcount - wmark, 16);

    // R10 cancel and reload
    wr(4, 'h00); idle(10);
    chk("R10 cancel moves nothing", wcount - wmark, 16);
    chk("R10 cancel ctrl", reg_ctrl, 'h00);
    pulse(); idle(40);
    chk("R10 pulse after cancel ignored", wcount - wmark, 16);
    setup('h3000, 'h8000);
    wr(4, 'h83);
    setup('h5000, 'h8200);
    w0 = wcount;
    wr(4, 'h81); idle(5);
    chk("R10 reload moves nothing", wcount - w0, 0);
    chk("R10 reload count", reg_ctrl, 'h01);
    pulse(); wait_idle();
    chk("R10 reload source used", first_rd, 'h5000);
    pulse(); wait_idle(); pulse(); idle(40);
    chk("R10 reload block total", wcount - wmark, 32);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule